// File: doc/BRIEF.md
# Host/DSP Doorbell Register Block

This block is a small bank of memory-mapped registers that lets a host processor and an embedded DSP exchange short command words in both directions. For host-to-DSP traffic, the host first loads an outbound extension word. It then writes the outbound primary word with its top bit set. That write rings the doorbell, and the DSP sees the message on dedicated output ports. The busy flag stays up until the DSP pulses a take strobe. When the DSP has finished the request, it pulses a done strobe. This raises a flag that the host clears by writing a one.

For DSP-to-host traffic, the DSP presents a primary word and an extension word and pulses a post strobe. The block latches both words and raises an inbound busy flag. The host clears that flag by writing a one once it has consumed the message. The done flag and the inbound busy flag can each raise an interrupt, and each has its own enable. A global enable gates the combined pending condition onto the interrupt output.

Top module: `ipc_doorbell_regs`

## Requirements
- R1: After reset, every mapped register reads zero, `irq` is low and `dsp_out_ring` is low. Reset is asserted asynchronously and released on the clock through a two-flop synchronizer.
- R2: A write to address 1 (outbound extension) stores `reg_wdata[30:0]` while the outbound busy flag is clear. It is shown on `dsp_out_ext` and read back in bits 30:0. While outbound busy is set, the payload part of the write is ignored.
- R3: A write to address 0 (outbound primary) while outbound busy is clear stores `reg_wdata[30:0]` on `dsp_out_pri` and loads bit 31 into the busy flag. The busy flag is read at address 0 bit 31 and driven on `dsp_out_ring` from the next cycle on.
- R4: Outbound busy stays set until a `dsp_take` pulse. It reads clear in the cycle after that pulse.
- R5: A write to address 0 while outbound busy is set changes nothing in the outbound words or busy flag, and it sets a sticky overflow flag at address 6 bit 1. Writing a one to address 6 bit 1 clears that flag; a new overflow in the same cycle wins.
- R6: A `dsp_done` pulse sets the done flag at address 1 bit 31. Writing a one to that bit clears it. When a pulse and a clear arrive in the same cycle, the pulse wins.
- R7: A `dsp_post` pulse while inbound busy is clear latches `dsp_in_pri` into address 2 bits 30:0 and `dsp_in_ext` into address 3. It also sets inbound busy (address 2 bit 31, `dsp_in_full`). A post while inbound busy is set is ignored. Writing a one to address 2 bit 31 clears inbound busy.
- R8: Address 4 holds the done interrupt enable in bit 0 and the inbound-message interrupt enable in bit 1. Address 6 bit 0 reads the pending condition (done AND bit 0) OR (inbound busy AND bit 1).
- R9: `irq` equals the pending condition gated by the global enable at address 5 bit 0. Clearing the done enable removes the interrupt without clearing the done flag.
- R10: Address 7 reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| dsp_out_pri | output | 31 | Outbound primary payload seen by the DSP |
| dsp_out_ext | output | 31 | Outbound extension payload seen by the DSP |
| dsp_out_ring | output | 1 | Outbound busy (doorbell rung) |
| dsp_take | input | 1 | DSP has taken the outbound message |
| dsp_done | input | 1 | DSP has completed the host request |
| dsp_post | input | 1 | DSP posts an inbound message |
| dsp_in_pri | input | 31 | Inbound primary payload from the DSP |
| dsp_in_ext | input | 32 | Inbound extension word from the DSP |
| dsp_in_full | output | 1 | Inbound busy flag, so the DSP holds further posts |
| irq | output | 1 | Combined IPC interrupt |

## Verification
Some properties are checked on every cycle:
- the outbound busy flag holds until a take pulse;
- the outbound primary word stays frozen while busy;
- overflow rises only after a primary write made while busy;
- the done and inbound busy flags set after their strobes;
- the interrupt stays low while the global enable is off.

The bench scenarios cover what a property cannot show alone:
- the exact read-back encoding at each address;
- the ordering of writing the extension before the primary;
- the mask, clear and unmask sequence on done;
- same-cycle set-versus-clear priority;
- the fact that a post while full leaves the earlier inbound words in place.

// File: rtl/ipc_db_pkg.sv
package ipc_db_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_OUT_PRI = 3'd0;
  localparam logic [ADDR_W-1:0] A_OUT_EXT = 3'd1;
  localparam logic [ADDR_W-1:0] A_IN_PRI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_IN_EXT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd4;
  localparam logic [ADDR_W-1:0] A_TOPEN   = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT    = 3'd6;

  localparam int unsigned CTRL_DONE_EN = 0;
  localparam int unsigned CTRL_BUSY_EN = 1;
  localparam int unsigned TOP_IPC_EN   = 0;
  localparam int unsigned STAT_PEND    = 0;
  localparam int unsigned STAT_OVF     = 1;
endpackage

// File: rtl/ipc_out_channel.sv
module ipc_out_channel #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PAY_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pri,
  input  logic              wr_ext,
  input  logic              ovf_clr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dsp_take,
  input  logic              dsp_done,
  output logic [PAY_W-1:0]  pri_q,
  output logic [PAY_W-1:0]  ext_q,
  output logic              busy_q,
  output logic              done_q,
  output logic              ovf_q
);
  logic             busy_d, done_d, ovf_d;
  logic             pri_ld, ext_ld;

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    ovf_d  = ovf_q;
    pri_ld = 1'b0;
    ext_ld = 1'b0;
    if (dsp_take) busy_d = 1'b0;
    if (ovf_clr)  ovf_d  = 1'b0;
    if (wr_pri) begin
      if (busy_q) begin
        ovf_d = 1'b1;
      end else begin
        pri_ld = 1'b1;
        busy_d = wdata[PAY_W];
      end
    end
    if (wr_ext) begin
      ext_ld = !busy_q;
      if (wdata[PAY_W]) done_d = 1'b0;
    end
    if (dsp_done) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q  <= '0;
      ext_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (pri_ld) pri_q <= wdata[PAY_W-1:0];
      if (ext_ld) ext_q <= wdata[PAY_W-1:0];
      busy_q <= busy_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
    end
  end
endmodule

// File: rtl/ipc_in_channel.sv
module ipc_in_channel #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PAY_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsp_post,
  input  logic [PAY_W-1:0]  dsp_pri,
  input  logic [DATA_W-1:0] dsp_ext,
  input  logic              busy_clr,
  output logic [PAY_W-1:0]  pri_q,
  output logic [DATA_W-1:0] ext_q,
  output logic              busy_q
);
  logic accept;
  logic busy_d;

  always_comb begin
    accept = dsp_post && !busy_q;
    busy_d = busy_q;
    if (busy_clr) busy_d = 1'b0;
    if (accept)   busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q  <= '0;
      ext_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (accept) begin
        pri_q <= dsp_pri;
        ext_q <= dsp_ext;
      end
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/ipc_irq_unit.sv
module ipc_irq_unit
  import ipc_db_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_top,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  input  logic              in_busy,
  output logic              done_en_q,
  output logic              busy_en_q,
  output logic              glb_en_q,
  output logic              pending,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_en_q <= 1'b0;
      busy_en_q <= 1'b0;
      glb_en_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        done_en_q <= wdata[CTRL_DONE_EN];
        busy_en_q <= wdata[CTRL_BUSY_EN];
      end
      if (wr_top) glb_en_q <= wdata[TOP_IPC_EN];
    end
  end

  always_comb begin
    pending = (done && done_en_q) || (in_busy && busy_en_q);
    irq     = pending && glb_en_q;
  end
endmodule

// File: rtl/ipc_doorbell_regs.sv
module ipc_doorbell_regs
  import ipc_db_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PAY_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [PAY_W-1:0]  dsp_out_pri,
  output logic [PAY_W-1:0]  dsp_out_ext,
  output logic              dsp_out_ring,
  input  logic              dsp_take,
  input  logic              dsp_done,
  input  logic              dsp_post,
  input  logic [PAY_W-1:0]  dsp_in_pri,
  input  logic [DATA_W-1:0] dsp_in_ext,
  output logic              dsp_in_full,
  output logic              irq
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic wr_out_pri, wr_out_ext, wr_in_pri, wr_ctrl, wr_top, wr_stat;
  always_comb begin
    wr_out_pri = reg_we && (reg_addr == A_OUT_PRI);
    wr_out_ext = reg_we && (reg_addr == A_OUT_EXT);
    wr_in_pri  = reg_we && (reg_addr == A_IN_PRI);
    wr_ctrl    = reg_we && (reg_addr == A_CTRL);
    wr_top     = reg_we && (reg_addr == A_TOPEN);
    wr_stat    = reg_we && (reg_addr == A_STAT);
  end

  logic [PAY_W-1:0]  out_pri, out_ext, in_pri;
  logic [DATA_W-1:0] in_ext;
  logic out_busy, out_done, out_ovf, in_busy;
  logic done_en, busy_en, glb_en, pending;

  ipc_out_channel #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_pri(wr_out_pri), .wr_ext(wr_out_ext),
    .ovf_clr(wr_stat && reg_wdata[STAT_OVF]),
    .wdata(reg_wdata), .dsp_take(dsp_take), .dsp_done(dsp_done),
    .pri_q(out_pri), .ext_q(out_ext), .busy_q(out_busy),
    .done_q(out_done), .ovf_q(out_ovf)
  );

  ipc_in_channel #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_sync_n),
    .dsp_post(dsp_post), .dsp_pri(dsp_in_pri), .dsp_ext(dsp_in_ext),
    .busy_clr(wr_in_pri && reg_wdata[PAY_W]),
    .pri_q(in_pri), .ext_q(in_ext), .busy_q(in_busy)
  );

  ipc_irq_unit #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_ctrl(wr_ctrl), .wr_top(wr_top), .wdata(reg_wdata),
    .done(out_done), .in_busy(in_busy),
    .done_en_q(done_en), .busy_en_q(busy_en), .glb_en_q(glb_en),
    .pending(pending), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_OUT_PRI: reg_rdata = {out_busy, out_pri};
      A_OUT_EXT: reg_rdata = {out_done, out_ext};
      A_IN_PRI:  reg_rdata = {in_busy, in_pri};
      A_IN_EXT:  reg_rdata = in_ext;
      A_CTRL: begin
        reg_rdata[CTRL_DONE_EN] = done_en;
        reg_rdata[CTRL_BUSY_EN] = busy_en;
      end
      A_TOPEN:   reg_rdata[TOP_IPC_EN] = glb_en;
      A_STAT: begin
        reg_rdata[STAT_PEND] = pending;
        reg_rdata[STAT_OVF]  = out_ovf;
      end
      default:   reg_rdata = '0;
    endcase
  end

  assign dsp_out_pri  = out_pri;
  assign dsp_out_ext  = out_ext;
  assign dsp_out_ring = out_busy;
  assign dsp_in_full  = in_busy;
endmodule

// File: rtl/ipc_doorbell_regs_chk.sv
module ipc_doorbell_regs_chk
  import ipc_db_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic              dsp_take,
  input logic              dsp_done,
  input logic              dsp_post,
  input logic              out_busy,
  input logic [DATA_W-2:0] out_pri,
  input logic              out_ovf,
  input logic              out_done,
  input logic              in_busy,
  input logic              glb_en,
  input logic              irq
);
  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_busy && !dsp_take) |=> out_busy);

  a_r3_pri_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_busy |=> $stable(out_pri));

  a_r5_ovf_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(out_ovf) |-> $past(reg_we && (reg_addr == A_OUT_PRI) && out_busy));

  a_r6_done_sets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dsp_done |=> out_done);

  a_r7_post_sets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dsp_post && !in_busy) |=> in_busy);

  a_r9_global_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !glb_en |-> !irq);
endmodule

bind ipc_doorbell_regs ipc_doorbell_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .dsp_take(dsp_take), .dsp_done(dsp_done), .dsp_post(dsp_post),
  .out_busy(out_busy), .out_pri(out_pri), .out_ovf(out_ovf),
  .out_done(out_done), .in_busy(in_busy), .glb_en(glb_en), .irq(irq)
);

// File: tb/ipc_doorbell_regs_test.sv
module ipc_doorbell_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [30:0] dsp_out_pri, dsp_out_ext;
  logic        dsp_out_ring, dsp_in_full, irq;
  logic        dsp_take = 1'b0, dsp_done = 1'b0, dsp_post = 1'b0;
  logic [30:0] dsp_in_pri = 31'h2BCD_1234;
  logic [31:0] dsp_in_ext = 32'hCAFE_0001;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ipc_doorbell_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dsp_out_pri(dsp_out_pri), .dsp_out_ext(dsp_out_ext),
    .dsp_out_ring(dsp_out_ring), .dsp_take(dsp_take), .dsp_done(dsp_done),
    .dsp_post(dsp_post), .dsp_in_pri(dsp_in_pri), .dsp_in_ext(dsp_in_ext),
    .dsp_in_full(dsp_in_full), .irq(irq)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [2:0]  ev;     // [2] take, [1] done, [0] post
    logic [2:0]  caddr;
    logic [31:0] exp;
    logic        eirq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd1, 32'h0000_0055, 3'b000, 3'd1, 32'h0000_0055, 1'b0, 8'd2},  // R2 ext first
    '{1'b1, 3'd0, 32'h8000_0011, 3'b000, 3'd0, 32'h8000_0011, 1'b0, 8'd3},  // R3 ring
    '{1'b1, 3'd0, 32'h8000_0022, 3'b000, 3'd0, 32'h8000_0011, 1'b0, 8'd5},  // R5 ignored
    '{1'b0, 3'd0, 32'h0,         3'b000, 3'd6, 32'h0000_0002, 1'b0, 8'd5},  // R5 overflow
    '{1'b1, 3'd1, 32'h0000_0077, 3'b000, 3'd1, 32'h0000_0055, 1'b0, 8'd2},  // R2 locked
    '{1'b0, 3'd0, 32'h0,         3'b100, 3'd0, 32'h0000_0011, 1'b0, 8'd4},  // R4 take
    '{1'b1, 3'd6, 32'h0000_0002, 3'b000, 3'd6, 32'h0000_0000, 1'b0, 8'd5},  // R5 w1c
    '{1'b1, 3'd4, 32'h0000_0003, 3'b000, 3'd4, 32'h0000_0003, 1'b0, 8'd8},  // R8 ctrl
    '{1'b0, 3'd0, 32'h0,         3'b010, 3'd6, 32'h0000_0001, 1'b0, 8'd8},  // R8 pending
    '{1'b1, 3'd5, 32'h0000_0001, 3'b000, 3'd5, 32'h0000_0001, 1'b1, 8'd9},  // R9 irq
    '{1'b1, 3'd4, 32'h0000_0002, 3'b000, 3'd1, 32'h8000_0055, 1'b0, 8'd9},  // R9 mask
    '{1'b1, 3'd1, 32'h8000_0055, 3'b000, 3'd1, 32'h0000_0055, 1'b0, 8'd6},  // R6 clear
    '{1'b1, 3'd4, 32'h0000_0003, 3'b000, 3'd6, 32'h0000_0000, 1'b0, 8'd8},  // R8 unmask
    '{1'b0, 3'd0, 32'h0,         3'b001, 3'd2, 32'hABCD_1234, 1'b1, 8'd7},  // R7 post
    '{1'b0, 3'd0, 32'h0,         3'b000, 3'd3, 32'hCAFE_0001, 1'b1, 8'd7},  // R7 ext
    '{1'b1, 3'd2, 32'h8000_0000, 3'b000, 3'd2, 32'h2BCD_1234, 1'b0, 8'd7},  // R7 w1c
    '{1'b1, 3'd7, 32'hFFFF_FFFF, 3'b000, 3'd7, 32'h0000_0000, 1'b0, 8'd10}, // R10 hole
    '{1'b0, 3'd0, 32'h0,         3'b000, 3'd4, 32'h0000_0003, 1'b0, 8'd10}  // R10 intact
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then read back caddr after the edge.
  task automatic step(input logic we, input logic [2:0] addr, input logic [31:0] wd,
                      input logic [2:0] ev, input logic [2:0] caddr);
    reg_we = we; reg_addr = addr; reg_wdata = wd;
    {dsp_take, dsp_done, dsp_post} = ev;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = caddr; reg_wdata = '0;
    {dsp_take, dsp_done, dsp_post} = 3'b000;
    #1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      reg_addr = 3'(a);
      #1;
      check("R1 reset read", reg_rdata, 32'h0);
    end
    check("R1 reset irq/ring", {30'h0, irq, dsp_out_ring}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].ev, VEC[i].caddr);
      checks++;
      if (reg_rdata !== VEC[i].exp || irq !== VEC[i].eirq) begin
        fails++;
        $display("FAIL R%0d vector %0d: actual %08h/irq%0b expected %08h/irq%0b",
                 VEC[i].req, i, reg_rdata, irq, VEC[i].exp, VEC[i].eirq);
      end
    end

    // R3 DSP-side ports carry the accepted outbound words
    check("R3 dsp_out_pri", {1'b0, dsp_out_pri}, 32'h11);
    check("R2 dsp_out_ext", {1'b0, dsp_out_ext}, 32'h55);

    // R6 done pulse and host clear in the same cycle: set wins
    step(1'b1, 3'd1, 32'h8000_0055, 3'b010, 3'd1);
    check("R6 set beats clear", reg_rdata, 32'h8000_0055);
    step(1'b1, 3'd1, 32'h8000_0055, 3'b000, 3'd1);
    check("R6 clear", reg_rdata, 32'h0000_0055);

    // R7 a post while inbound busy leaves the first message in place
    step(1'b0, 3'd0, 32'h0, 3'b001, 3'd2);
    check("R7 full flag", {31'h0, dsp_in_full}, 32'h1);
    dsp_in_pri = 31'h0000_0BAD; dsp_in_ext = 32'h1111_2222;
    step(1'b0, 3'd0, 32'h0, 3'b001, 3'd3);
    check("R7 post ignored ext", reg_rdata, 32'hCAFE_0001);
    reg_addr = 3'd2; #1;
    check("R7 post ignored pri", reg_rdata, 32'hABCD_1234);
    step(1'b1, 3'd2, 32'h8000_0000, 3'b000, 3'd2);
    check("R7 released", reg_rdata, 32'h2BCD_1234);

    // R4 busy persists without a take
    step(1'b1, 3'd0, 32'h8000_0044, 3'b000, 3'd0);
    repeat (3) @(negedge clk);
    #1;
    check("R4 busy held", {reg_rdata[31], 30'h0, dsp_out_ring}, 32'h8000_0001);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule